// File: doc/BRIEF.md
# Eight-pin GPIO port register file

This block is the register side of an 8-pin general-purpose I/O port, reached over a simple 32-bit register bus with a 4 KB address window. It holds the pin data and pin direction. Pins set as outputs drive the stored data. Pins set as inputs are sampled into the data register on every clock. Data accesses are masked by address bits, so software can read or change any subset of pins with one access and no read-modify-write.

The block also stores a bank of pad-setup bytes and an alternate-function selection. It does not act on the pad bytes; a pad ring would use them. Changes to the alternate-function selection are gated by a commit byte. The commit byte can only be rewritten after a fixed 32-bit key has been written to the lock word. A read-only area at the top of the window returns fixed identification bytes. Interrupt detection is a separate block, and its offsets are not decoded here.

The bus has a single-cycle read strobe and a single-cycle write strobe. Read data and the error flag appear in the cycle after the strobe.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the following values hold: every stored byte is zero, the lock word reads 1, the commit byte reads 0xFF, every pin_out line is high, bus_rdata is zero and bus_err is low.
- R2: A read of any word offset 0x000–0x3FC returns the data register ANDed with address bits [9:2], zero-extended. Bit n of the mask gates pin n.
- R3: A write in offset 0x000–0x3FC changes a data bit only where address bit [n+2] is set and pin n is an output. Every other output data bit keeps its value.
- R4: The direction byte sits at offset 0x400, with 1 meaning output. A write keeps only wdata[7:0], and a read returns the byte.
- R5: pin_out[n] equals data bit n when pin n is an output, and is 1 when pin n is an input.
- R6: For every pin set as an input, the data bit takes the level of pin_in on each clock edge, one cycle after the pin changes. An output pin's data bit ignores pin_in.
- R7: Writing 0x0ACCE551 to offset 0x520 unlocks the port, and writing any other value locks it. A read of 0x520 returns 1 in bit 0 when locked and 0 when unlocked.
- R8: The commit byte at offset 0x524 takes wdata[7:0] only while the port is unlocked. A read returns it.
- R9: A write to the alternate-function byte at offset 0x420 changes only the bits that are set in the commit byte. A read returns the byte.
- R10: Nine pad bytes are stored: eight at offsets 0x500–0x51C and one at 0x528. Each keeps wdata[7:0] and reads it back.
- R11: Word offsets 0xFD0–0xFFC read, in rising address order, the bytes 00 00 00 00 61 10 04 00 0D F0 05 B1. A write there changes nothing and raises bus_err.
- R12: Any other offset reads zero and ignores writes. bus_err is high for exactly the one cycle after each such access and stays low after every mapped access.
- R13: bus_rdata is updated only in the cycle after a read strobe and holds its value until the next read. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| bus_err | output | 1 | One-cycle flag for an unmapped or read-only access |
| pin_in | input | 8 | Pin levels, synchronous to clk |
| pin_out | output | 8 | Pin drive values |

## Verification
The assertions assume the following about the inputs:
- bus_rd and bus_wr are never high together.
- pin_in is already synchronous to clk, because the data bits of input pins copy it directly on each edge.

The bench keeps within these assumptions in three ways. It drives every input on the falling edge. It issues one strobe per access. It changes pin_in only on its own, with at least one clock before the next read. As a result, every sampled pin value is settled and no access overlaps another.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // word offsets (byte offset >> 2) inside the 4 KB window
   localparam logic [9:0] WORD_DIR    = 10'h100;
   localparam logic [9:0] WORD_AFSEL  = 10'h108;
   localparam logic [9:0] WORD_PAD0   = 10'h140;
   localparam logic [9:0] WORD_LOCK   = 10'h148;
   localparam logic [9:0] WORD_COMMIT = 10'h149;
   localparam logic [9:0] WORD_ANALOG = 10'h14A;
   localparam logic [9:0] WORD_ID0    = 10'h3F4;

   localparam int unsigned NUM_PAD = 9;   // eight drive/pull/slew/enable bytes plus analog
   localparam int unsigned SUB_W   = 4;   // sub-index width for pad and id words
   localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_DATA,
      TGT_DIR,
      TGT_AFSEL,
      TGT_PAD,
      TGT_LOCK,
      TGT_COMMIT,
      TGT_ID
   } tgt_e;

   // identification byte for id word idx (R11)
   function automatic logic [7:0] id_byte(input logic [SUB_W-1:0] idx);
      logic [7:0] b;
      case (idx)
         4'd4:    b = 8'h61;
         4'd5:    b = 8'h10;
         4'd6:    b = 8'h04;
         4'd8:    b = 8'h0D;
         4'd9:    b = 8'hF0;
         4'd10:   b = 8'h05;
         4'd11:   b = 8'hB1;
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_port_pkg::*;
(
   input  logic [9:0]       word,
   output tgt_e             tgt,
   output logic [SUB_W-1:0] sub_idx
);

   always_comb begin
      tgt     = TGT_NONE;
      sub_idx = '0;
      if (word < WORD_DIR) begin
         tgt = TGT_DATA;
      end else if (word == WORD_DIR) begin
         tgt = TGT_DIR;
      end else if (word == WORD_AFSEL) begin
         tgt = TGT_AFSEL;
      end else if (word >= WORD_PAD0 && word < WORD_LOCK) begin
         tgt     = TGT_PAD;
         sub_idx = SUB_W'(word - WORD_PAD0);
      end else if (word == WORD_LOCK) begin
         tgt = TGT_LOCK;
      end else if (word == WORD_COMMIT) begin
         tgt = TGT_COMMIT;
      end else if (word == WORD_ANALOG) begin
         tgt     = TGT_PAD;
         sub_idx = SUB_W'(NUM_PAD - 1);
      end else if (word >= WORD_ID0) begin
         tgt     = TGT_ID;
         sub_idx = SUB_W'(word - WORD_ID0);
      end
   end

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_wr,
   input  logic             dir_wr,
   input  logic [NPINS-1:0] wdata,
   input  logic [NPINS-1:0] sel_mask,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] data_q,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] pin_out
);

   // direction byte, 1 = output (R4)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (dir_wr) dir_q <= wdata;
   end

   // one data flop per pin: inputs sample, outputs take masked writes (R3, R6)
   for (genvar g = 0; g < NPINS; g++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     data_q[g] <= 1'b0;
         else if (!dir_q[g])             data_q[g] <= pin_in[g];
         else if (data_wr && sel_mask[g]) data_q[g] <= wdata[g];
      end
      assign pin_out[g] = dir_q[g] ? data_q[g] : 1'b1;   // R5
   end

   p_input_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((data_q ^ $past(pin_in)) & ~$past(dir_q)) == '0)
      else $error("input pin data bit did not follow pin_in");

   p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((data_q ^ $past(data_q)) & $past(dir_q)
                & ~$past({NPINS{data_wr}} & sel_mask)) == '0)
      else $error("unselected output data bit changed");

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS = 8,
   parameter int unsigned DW    = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            afsel_wr,
   input  logic                            lock_wr,
   input  logic                            commit_wr,
   input  logic                            pad_wr,
   input  logic [SUB_W-1:0]                pad_idx,
   input  logic [DW-1:0]                   wdata,
   output logic [NPINS-1:0]                afsel_q,
   output logic [NPINS-1:0]                commit_q,
   output logic                            locked_q,
   output logic [NUM_PAD-1:0][NPINS-1:0]   pad_q
);

   // key lock (R7)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       locked_q <= 1'b1;
      else if (lock_wr) locked_q <= (wdata != UNLOCK_KEY);
   end

   // commit byte, writable only while unlocked (R8)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      commit_q <= '1;
      else if (commit_wr && !locked_q) commit_q <= wdata[NPINS-1:0];
   end

   // alternate-function byte, per-bit gated by commit (R9)
   for (genvar g = 0; g < NPINS; g++) begin : g_afsel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      afsel_q[g] <= 1'b0;
         else if (afsel_wr && commit_q[g]) afsel_q[g] <= wdata[g];
      end
   end

   // pad-setup bytes (R10)
   for (genvar p = 0; p < NUM_PAD; p++) begin : g_pad
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              pad_q[p] <= '0;
         else if (pad_wr && pad_idx == SUB_W'(p)) pad_q[p] <= wdata[NPINS-1:0];
      end
   end

   p_lock_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && wdata == UNLOCK_KEY) |=> !locked_q)
      else $error("key write did not unlock");

   p_commit_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> $stable(commit_q))
      else $error("commit byte changed while locked");

   p_afsel_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((afsel_q ^ $past(afsel_q)) & ~$past(commit_q)) == '0)
      else $error("uncommitted alternate-function bit changed");

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS = 8,
   parameter int unsigned AW    = 12,
   parameter int unsigned DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   input  logic             bus_rd,
   input  logic             bus_wr,
   output logic [DW-1:0]    bus_rdata,
   output logic             bus_err,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out
);

   localparam int unsigned PAD_IW = $clog2(NUM_PAD);

   // elaboration-time parameter checks
   if (NPINS < 1 || NPINS > 8) begin : g_bad_npins
      initial $fatal(1, "NPINS must be 1..8");
   end
   if (AW != 12) begin : g_bad_aw
      initial $fatal(1, "AW must be 12 for a 4 KB window");
   end
   if (DW < 32) begin : g_bad_dw
      initial $fatal(1, "DW must be at least 32");
   end

   wire unused_byte_lane = ^bus_addr[1:0];   // R13: byte lane ignored

   tgt_e             tgt;
   logic [SUB_W-1:0] sub_idx;
   logic [NPINS-1:0] rd_mask;
   logic [NPINS-1:0] data_q, dir_q, afsel_q, commit_q;
   logic             locked_q;
   logic [NUM_PAD-1:0][NPINS-1:0] pad_q;
   logic [DW-1:0]    rd_val;
   logic             bad_access;

   assign rd_mask = bus_addr[NPINS+1:2];

   gpio_addr_decode u_dec (
      .word    (bus_addr[11:2]),
      .tgt     (tgt),
      .sub_idx (sub_idx)
   );

   gpio_pin_bank #(.NPINS(NPINS)) u_pins (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (bus_wr && tgt == TGT_DATA),
      .dir_wr   (bus_wr && tgt == TGT_DIR),
      .wdata    (bus_wdata[NPINS-1:0]),
      .sel_mask (rd_mask),
      .pin_in   (pin_in),
      .data_q   (data_q),
      .dir_q    (dir_q),
      .pin_out  (pin_out)
   );

   gpio_cfg_bank #(.NPINS(NPINS), .DW(DW)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .afsel_wr  (bus_wr && tgt == TGT_AFSEL),
      .lock_wr   (bus_wr && tgt == TGT_LOCK),
      .commit_wr (bus_wr && tgt == TGT_COMMIT),
      .pad_wr    (bus_wr && tgt == TGT_PAD),
      .pad_idx   (sub_idx),
      .wdata     (bus_wdata),
      .afsel_q   (afsel_q),
      .commit_q  (commit_q),
      .locked_q  (locked_q),
      .pad_q     (pad_q)
   );

   // read mux (R2, R4, R7..R11)
   always_comb begin
      rd_val = '0;
      case (tgt)
         TGT_DATA:   rd_val[NPINS-1:0] = data_q & rd_mask;
         TGT_DIR:    rd_val[NPINS-1:0] = dir_q;
         TGT_AFSEL:  rd_val[NPINS-1:0] = afsel_q;
         TGT_PAD:    rd_val[NPINS-1:0] = pad_q[sub_idx[PAD_IW-1:0]];
         TGT_LOCK:   rd_val[0]         = locked_q;
         TGT_COMMIT: rd_val[NPINS-1:0] = commit_q;
         TGT_ID:     rd_val[7:0]       = id_byte(sub_idx);
         default:    rd_val            = '0;
      endcase
   end

   // R11, R12: unmapped access, or write into the read-only id area
   assign bad_access = (bus_rd || bus_wr) &&
                       (tgt == TGT_NONE || (bus_wr && tgt == TGT_ID));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         if (bus_rd) bus_rdata <= rd_val;   // R13
         bus_err <= bad_access;
      end
   end

   p_single_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr))
      else $error("read and write strobes together");

   p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata))
      else $error("read data changed without a read");

   p_err_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_rd || bus_wr))
      else $error("error flag without an access");

   p_mapped_no_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && tgt != TGT_NONE) |=> !bus_err)
      else $error("error flag on a mapped read");

   p_inputs_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (~dir_q & ~pin_out) == '0)
      else $error("input pin drives low");

endmodule

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;

   int n_checks = 0;
   int n_fail   = 0;

   // model state
   logic [7:0] m_data = '0, m_dir = '0, m_afsel = '0, m_commit = 8'hFF;
   logic       m_locked = 1'b1;
   logic [7:0] m_pad [9];

   always #4 clk = ~clk;   // 125 MHz

   gpio_port_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .pin_in(pin_in), .pin_out(pin_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_data();
      return (m_data & m_dir) | (pin_in & ~m_dir);
   endfunction

   function automatic logic [7:0] id_exp(input int i);
      logic [7:0] t [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10,
                             8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      return t[i];
   endfunction

   function automatic string req_of(input logic [11:0] a);
      logic [9:0] w = a[11:2];
      if (w < 10'h100) return "R2";
      if (w == 10'h100) return "R4";
      if (w == 10'h108) return "R9";
      if ((w >= 10'h140 && w < 10'h148) || w == 10'h14A) return "R10";
      if (w == 10'h148) return "R7";
      if (w == 10'h149) return "R8";
      if (w >= 10'h3F4) return "R11";
      return "R12";
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      logic [9:0] w = a[11:2];
      if (w < 10'h100) return {24'h0, exp_data() & w[7:0]};
      if (w == 10'h100) return {24'h0, m_dir};
      if (w == 10'h108) return {24'h0, m_afsel};
      if (w >= 10'h140 && w < 10'h148) return {24'h0, m_pad[w - 10'h140]};
      if (w == 10'h14A) return {24'h0, m_pad[8]};
      if (w == 10'h148) return {31'h0, m_locked};
      if (w == 10'h149) return {24'h0, m_commit};
      if (w >= 10'h3F4) return {24'h0, id_exp(int'(w - 10'h3F4))};
      return 32'h0;
   endfunction

   function automatic logic exp_bad(input logic [11:0] a, input logic is_wr);
      string r = req_of(a);
      return (r == "R12") || (is_wr && r == "R11");
   endfunction

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      logic [9:0] w = a[11:2];
      logic [7:0] m;
      if (w < 10'h100) begin
         m = w[7:0] & m_dir;
         m_data = (m_data & ~m) | (d[7:0] & m);
      end else if (w == 10'h100) begin
         m_data = exp_data();
         m_dir  = d[7:0];
      end else if (w == 10'h108) begin
         m_afsel = (m_afsel & ~m_commit) | (d[7:0] & m_commit);
      end else if (w >= 10'h140 && w < 10'h148) begin
         m_pad[w - 10'h140] = d[7:0];
      end else if (w == 10'h14A) begin
         m_pad[8] = d[7:0];
      end else if (w == 10'h148) begin
         m_locked = (d != 32'h0ACCE551);
      end else if (w == 10'h149) begin
         if (!m_locked) m_commit = d[7:0];
      end
   endtask

   task automatic do_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk(exp_bad(a, 1'b1) ? req_of(a) : "R12", {31'h0, bus_err}, {31'h0, exp_bad(a, 1'b1)});
      model_write(a, d);
   endtask

   task automatic do_read(input logic [11:0] a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req_of(a), bus_rdata, exp_read(a));
      chk("R12", {31'h0, bus_err}, {31'h0, exp_bad(a, 1'b0)});
   endtask

   task automatic set_pins(input logic [7:0] v);
      @(negedge clk);
      pin_in = v;
      @(negedge clk);
   endtask

   task automatic chk_pins();
      chk("R5", {24'h0, pin_out}, {24'h0, (exp_data() & m_dir) | ~m_dir});
   endtask

   function automatic logic [11:0] pick_addr();
      case ($urandom_range(0, 9))
         0:       return {2'b00, 8'($urandom), 2'b00};
         1:       return 12'h400;
         2:       return 12'h420;
         3:       return 12'h500 + 12'(4 * $urandom_range(0, 7));
         4:       return 12'h528;
         5:       return 12'h520;
         6:       return 12'h524;
         7:       return 12'hFD0 + 12'(4 * $urandom_range(0, 11));
         8:       return 12'($urandom);
         default: return 12'h404 + 12'(4 * $urandom_range(0, 6));
      endcase
   endfunction

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] seed_dummy;
      logic [31:0] held;
      for (int i = 0; i < 9; i++) m_pad[i] = '0;
      seed_dummy = $urandom(32'h00C0_FFEE);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1", bus_rdata, 32'h0);
      chk("R1", {31'h0, bus_err}, 32'h0);
      chk("R1", {24'h0, pin_out}, 32'hFF);
      do_read(12'h520); do_read(12'h524); do_read(12'h400);
      do_read(12'h420); do_read(12'h500); do_read(12'h528); do_read(12'h3FC);

      // R4: direction, upper bits dropped
      do_write(12'h400, 32'hFFFF_FF0F); do_read(12'h400);
      do_write(12'h400, 32'h0000_00F0); do_read(12'h400);

      // R3 / R2: masked data write and read
      do_write(12'h3FC, 32'h0000_00A5); chk_pins();
      do_read(12'h3C0);
      do_write(12'h0C0, 32'h0000_00FF); chk_pins();   // only pins 4,5
      do_read(12'h3FC);
      do_read(12'h004);
      do_read(12'h3C1);                                // R13 byte lane ignored

      // R6: input pins follow, output pins ignore pin_in
      set_pins(8'h5A); do_read(12'h3FC); chk_pins();
      set_pins(8'hA5); do_read(12'h3FC); chk_pins();
      do_write(12'h400, 32'h0000_000F); chk_pins();   // inputs turn outputs, keep level
      do_read(12'h3FC);

      // R7 / R8 / R9: lock, commit, alternate function
      do_write(12'h524, 32'h0000_000F); do_read(12'h524);   // locked: ignored
      do_write(12'h420, 32'h0000_00C3); do_read(12'h420);
      do_write(12'h520, 32'h0ACC_E551); do_read(12'h520);
      do_write(12'h524, 32'h0000_000F); do_read(12'h524);
      do_write(12'h520, 32'h0000_0000); do_read(12'h520);
      do_write(12'h420, 32'h0000_00FF); do_read(12'h420);
      do_write(12'h524, 32'h0000_0000); do_read(12'h524);

      // R10: pad bytes
      for (int i = 0; i < 8; i++) do_write(12'h500 + 12'(4 * i), 32'hFFFF_FF00 | 32'(i * 17 + 3));
      do_write(12'h528, 32'h1234_5699);
      for (int i = 0; i < 8; i++) do_read(12'h500 + 12'(4 * i));
      do_read(12'h528);

      // R11: id area, write flagged and ignored
      for (int i = 0; i < 12; i++) do_read(12'hFD0 + 12'(4 * i));
      do_write(12'hFE0, 32'hFFFF_FFFF); do_read(12'hFE0);

      // R12: unmapped, one-cycle flag
      do_read(12'h404);
      @(negedge clk); chk("R12", {31'h0, bus_err}, 32'h0);
      do_write(12'h41C, 32'hFFFF_FFFF);
      do_read(12'h800);

      // R13: read data holds
      do_read(12'h400);
      held = bus_rdata;
      do_write(12'h500, 32'h0000_0077);
      repeat (3) @(negedge clk);
      chk("R13", bus_rdata, held);

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         logic [11:0] a;
         logic [31:0] d;
         case ($urandom_range(0, 5))
            0, 3: begin
               a = pick_addr();
               d = $urandom;
               if (a[11:2] == 10'h148 && $urandom_range(0, 1) == 1) d = 32'h0ACC_E551;
               do_write(a, d);
            end
            1, 4: do_read(pick_addr());
            default: set_pins(8'($urandom));
         endcase
         chk_pins();
      end

      summary();
      $finish;
   end

endmodule